// File: doc/BRIEF.md
# Parity Poison Forwarding Stage

This block is a single register stage placed between two interfaces that move data with one even-parity bit per byte lane. Every accepted beat is checked lane by lane. The outgoing parity is computed again from the data. Any lane that arrived with a parity mismatch leaves with its parity bit deliberately inverted. A corrupted beat is never repaired: the downstream side always sees the fault as poison. No setting exists that clears the poison.

Each beat carries two tags: a write tag and a tag that marks the designated internal controller as its target. A write aimed at that controller is discarded once any of its beats shows a parity fault. The beat that has the fault is dropped, and so is every later beat of the same burst, up to and including the beat marked last. Dropped beats are still accepted upstream, so the sender never waits on them. A parity fault is reported on a one-cycle error pulse. In immediate mode the pulse follows the receipt of the faulty beat. In deferred mode nothing is reported on receipt. A separate consumption-side port checks data as it is used, and a fault seen there raises the pulse instead.

Top module: `parity_poison_stage`

## Requirements
- R1: While reset is held and in the first cycle after it, `m_valid` and `err_pulse` are 0 and `s_ready` is 1.
- R2: A beat that is accepted (`s_valid` and `s_ready` high at a rising edge) and not dropped appears on `m_valid`, `m_data`, `m_last`, `m_write` and `m_ctl` right after that same edge, unchanged.
- R3: Parity is even per byte lane: bit i of a parity vector equals the XOR of data bits [8i+7:8i]. With the default lane-only poisoning, `m_par` bit i is the correct parity of lane i, inverted exactly when lane i arrived with a mismatch. The result is equal to the received `s_par`.
- R4: `s_ready` equals `!m_valid || m_ready`. While `m_valid` is high and `m_ready` is low, the output beat is held unchanged.
- R5: A beat with `s_write`=1 and `s_ctl`=1 that has a parity mismatch in any lane is accepted but never forwarded.
- R6: After a beat is dropped under R5, every later beat of that controller-write burst is also dropped, up to and including the beat with `s_last`=1. The next burst is forwarded normally.
- R7: A controller write with good parity is forwarded. A faulty beat that is not a controller write (a read, or a write to another target) is forwarded with poisoned parity.
- R8: With `defer_mode`=0, `err_pulse` is high for exactly the one cycle after the edge that accepts a beat with any parity mismatch. This includes beats that are dropped.
- R9: With `defer_mode`=1, receiving a faulty beat raises no pulse. A consumption beat (`use_valid`=1) whose `use_par` mismatches `use_data` in any lane raises `err_pulse` for the one cycle after that edge. A clean consumption beat raises no pulse.
- R10: With `defer_mode`=0, the consumption port has no effect on `err_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| defer_mode | input | 1 | 0 = report faults on receipt, 1 = report on consumption |
| s_valid | input | 1 | Upstream beat valid |
| s_ready | output | 1 | Stage can accept a beat |
| s_data | input | DATA_W | Upstream data |
| s_par | input | DATA_W/8 | Upstream even parity, one bit per byte lane |
| s_last | input | 1 | Final beat of a burst |
| s_write | input | 1 | Beat belongs to a write |
| s_ctl | input | 1 | Beat targets the designated internal controller |
| m_valid | output | 1 | Downstream beat valid |
| m_ready | input | 1 | Downstream accepts the beat |
| m_data | output | DATA_W | Forwarded data |
| m_par | output | DATA_W/8 | Regenerated parity, poisoned on faulty lanes |
| m_last | output | 1 | Forwarded last tag |
| m_write | output | 1 | Forwarded write tag |
| m_ctl | output | 1 | Forwarded controller-target tag |
| use_valid | input | 1 | Consumption-side beat valid |
| use_data | input | DATA_W | Data being consumed |
| use_par | input | DATA_W/8 | Parity of the consumed data |
| err_pulse | output | 1 | One-cycle parity error event |

## Verification
Every result of this stage appears one edge after its cause. A forwarded beat shows on the `m_*` outputs right after the edge that accepts it, and `err_pulse` rises right after the edge that accepts a faulty beat or sees a faulty consumption beat. `s_ready` is combinational and shows at once. The bench drives inputs on the falling edge and lets one rising edge pass. It samples on the next falling edge, before it drives the next stimulus. It then idles one more cycle so that every table vector starts from an empty stage. For the burst and backpressure cases the same one-edge rule applies to each beat in turn.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

   localparam int LANE_W = 8;

   typedef enum logic {
      REPORT_ON_RECEIPT = 1'b0,
      REPORT_ON_USE     = 1'b1
   } report_mode_e;

   // even parity bit for one byte lane
   function automatic logic lane_parity(input logic [LANE_W-1:0] b);
      return ^b;
   endfunction

endpackage

// File: rtl/ppf_lane_check.sv
module ppf_lane_check #(
   parameter int LANES = 4
) (
   input  logic [LANES*ppf_pkg::LANE_W-1:0] data,
   input  logic [LANES-1:0]                 par,
   output logic [LANES-1:0]                 bad_lane
);
   localparam int LW = ppf_pkg::LANE_W;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign bad_lane[i] = ppf_pkg::lane_parity(data[i*LW +: LW]) ^ par[i];
   end

endmodule

// File: rtl/ppf_poison.sv
module ppf_poison #(
   parameter int LANES      = 4,
   parameter bit POISON_ALL = 1'b0
) (
   input  logic [LANES*ppf_pkg::LANE_W-1:0] data,
   input  logic [LANES-1:0]                 bad_lane,
   output logic [LANES-1:0]                 out_par
);
   localparam int LW = ppf_pkg::LANE_W;

   logic [LANES-1:0] regen;

   for (genvar i = 0; i < LANES; i++) begin : g_regen
      assign regen[i] = ppf_pkg::lane_parity(data[i*LW +: LW]);
   end

   if (POISON_ALL) begin : g_all
      assign out_par = regen ^ {LANES{|bad_lane}};
   end else begin : g_lane_only
      assign out_par = regen ^ bad_lane;
   end

endmodule

// File: rtl/ppf_drop_ctl.sv
module ppf_drop_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic is_write,
   input  logic is_ctl,
   input  logic any_bad,
   input  logic is_last,
   output logic drop_now
);
   logic in_drop;

   assign drop_now = is_write & is_ctl & (any_bad | in_drop);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_drop <= 1'b0;
      end else if (accept) begin
         if (is_last)       in_drop <= 1'b0;
         else if (drop_now) in_drop <= 1'b1;
      end
   end

   // R6
   drop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_drop) |-> $past(any_bad && is_write && is_ctl));

   // R6
   drop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && is_last) |=> !in_drop);

endmodule

// File: rtl/ppf_err_report.sv
module ppf_err_report #(
   parameter int LANES = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             defer,
   input  logic                             accept_bad,
   input  logic                             use_valid,
   input  logic [LANES*ppf_pkg::LANE_W-1:0] use_data,
   input  logic [LANES-1:0]                 use_par,
   output logic                             err_pulse
);
   import ppf_pkg::*;

   logic [LANES-1:0] use_bad;
   logic             use_hit;
   report_mode_e     mode;

   ppf_lane_check #(.LANES(LANES)) u_use_chk (
      .data     (use_data),
      .par      (use_par),
      .bad_lane (use_bad)
   );

   assign use_hit = use_valid & (|use_bad);
   assign mode    = report_mode_e'(defer);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_pulse <= 1'b0;
      end else begin
         case (mode)
            REPORT_ON_USE: err_pulse <= use_hit;
            default:       err_pulse <= accept_bad;
         endcase
      end
   end

   // R9
   defer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (defer && !use_hit) |=> !err_pulse);

   // R9
   defer_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (defer && use_hit) |=> err_pulse);

   // R10
   imm_ignore_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!defer && !accept_bad) |=> !err_pulse);

endmodule

// File: rtl/parity_poison_stage.sv
module parity_poison_stage #(
   parameter int DATA_W     = 32,
   parameter bit POISON_ALL = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                defer_mode,
   input  logic                s_valid,
   output logic                s_ready,
   input  logic [DATA_W-1:0]   s_data,
   input  logic [DATA_W/8-1:0] s_par,
   input  logic                s_last,
   input  logic                s_write,
   input  logic                s_ctl,
   output logic                m_valid,
   input  logic                m_ready,
   output logic [DATA_W-1:0]   m_data,
   output logic [DATA_W/8-1:0] m_par,
   output logic                m_last,
   output logic                m_write,
   output logic                m_ctl,
   input  logic                use_valid,
   input  logic [DATA_W-1:0]   use_data,
   input  logic [DATA_W/8-1:0] use_par,
   output logic                err_pulse
);
   localparam int LANES = DATA_W / ppf_pkg::LANE_W;

   if ((DATA_W % ppf_pkg::LANE_W) != 0 || DATA_W < ppf_pkg::LANE_W) begin : g_width_bad
      $error("parity_poison_stage: DATA_W must be a nonzero multiple of the lane width");
   end

   logic [LANES-1:0] bad_lane;
   logic [LANES-1:0] tx_par;
   logic             any_bad;
   logic             accept;
   logic             drop_now;

   ppf_lane_check #(.LANES(LANES)) u_rx_chk (
      .data     (s_data),
      .par      (s_par),
      .bad_lane (bad_lane)
   );

   ppf_poison #(.LANES(LANES), .POISON_ALL(POISON_ALL)) u_poison (
      .data     (s_data),
      .bad_lane (bad_lane),
      .out_par  (tx_par)
   );

   assign any_bad = |bad_lane;
   assign s_ready = !m_valid || m_ready;
   assign accept  = s_valid && s_ready;

   ppf_drop_ctl u_drop (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .is_write (s_write),
      .is_ctl   (s_ctl),
      .any_bad  (any_bad),
      .is_last  (s_last),
      .drop_now (drop_now)
   );

   ppf_err_report #(.LANES(LANES)) u_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .defer      (defer_mode),
      .accept_bad (accept && any_bad),
      .use_valid  (use_valid),
      .use_data   (use_data),
      .use_par    (use_par),
      .err_pulse  (err_pulse)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
      end else if (accept && !drop_now) begin
         m_valid <= 1'b1;
      end else if (m_ready) begin
         m_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_data  <= '0;
         m_par   <= '0;
         m_last  <= 1'b0;
         m_write <= 1'b0;
         m_ctl   <= 1'b0;
      end else if (accept && !drop_now) begin
         m_data  <= s_data;
         m_par   <= tx_par;
         m_last  <= s_last;
         m_write <= s_write;
         m_ctl   <= s_ctl;
      end
   end

   // R2
   fwd_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !drop_now) |=> (m_valid && m_data == $past(s_data)));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_par)));

   // R5
   drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && s_write && s_ctl && any_bad) |=> !m_valid);

   // R8
   imm_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!defer_mode && accept && any_bad) |=> err_pulse);

   if (!POISON_ALL) begin : g_lane_poison_chk
      // R3
      poison_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (accept && !drop_now) |=> (m_par == $past(s_par)));
   end

endmodule

// File: tb/parity_poison_stage_tb.sv
module parity_poison_stage_tb_top;

   localparam int DW = 32;
   localparam int PW = DW / 8;
   localparam int NV = 8;

   // {defer, data, par, write, ctl, exp_fwd, exp_err}
   localparam logic [40:0] VEC [NV] = '{
      {1'b0, 32'h07030100, 4'hA, 1'b0, 1'b0, 1'b1, 1'b0},
      {1'b0, 32'h07030100, 4'hB, 1'b0, 1'b0, 1'b1, 1'b1},
      {1'b0, 32'hFFFFFFFF, 4'h5, 1'b1, 1'b1, 1'b0, 1'b1},
      {1'b0, 32'hFFFFFFFF, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0},
      {1'b0, 32'h07030100, 4'hB, 1'b1, 1'b0, 1'b1, 1'b1},
      {1'b1, 32'h07030100, 4'hB, 1'b0, 1'b0, 1'b1, 1'b0},
      {1'b1, 32'hFFFFFFFF, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0},
      {1'b0, 32'h07030100, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          defer_mode = 1'b0;
   logic          s_valid = 1'b0;
   logic          s_ready;
   logic [DW-1:0] s_data = '0;
   logic [PW-1:0] s_par = '0;
   logic          s_last = 1'b0;
   logic          s_write = 1'b0;
   logic          s_ctl = 1'b0;
   logic          m_valid;
   logic          m_ready = 1'b1;
   logic [DW-1:0] m_data;
   logic [PW-1:0] m_par;
   logic          m_last;
   logic          m_write;
   logic          m_ctl;
   logic          use_valid = 1'b0;
   logic [DW-1:0] use_data = '0;
   logic [PW-1:0] use_par = '0;
   logic          err_pulse;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   parity_poison_stage #(.DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .defer_mode(defer_mode),
      .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_par(s_par),
      .s_last(s_last), .s_write(s_write), .s_ctl(s_ctl),
      .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_par(m_par),
      .m_last(m_last), .m_write(m_write), .m_ctl(m_ctl),
      .use_valid(use_valid), .use_data(use_data), .use_par(use_par),
      .err_pulse(err_pulse)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [DW-1:0] d, input logic [PW-1:0] p,
                        input logic w, input logic c, input logic l);
      s_valid = 1'b1; s_data = d; s_par = p; s_write = w; s_ctl = c; s_last = l;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 m_valid in reset", 32'(m_valid), 32'd0);
      chk("R1 err_pulse in reset", 32'(err_pulse), 32'd0);
      rst_n = 1'b1;
      step();
      chk("R1 m_valid after reset", 32'(m_valid), 32'd0);
      chk("R1 s_ready after reset", 32'(s_ready), 32'd1);

      // table walk: single-beat transfers, m_ready high
      for (int i = 0; i < NV; i++) begin
         defer_mode = VEC[i][40];
         drive(VEC[i][39:8], VEC[i][7:4], VEC[i][3], VEC[i][2], 1'b1);
         #1;
         chk("R4 s_ready when empty", 32'(s_ready), 32'd1);
         step();
         chk("R5 R7 forwarded", 32'(m_valid), 32'(VEC[i][1]));
         if (VEC[i][1]) begin
            chk("R2 data", m_data, VEC[i][39:8]);
            chk("R3 parity", 32'(m_par), 32'(VEC[i][7:4]));
            chk("R2 tags", {30'd0, m_write, m_ctl}, {30'd0, VEC[i][3], VEC[i][2]});
         end
         chk("R8 R9 error pulse", 32'(err_pulse), 32'(VEC[i][0]));
         s_valid = 1'b0;
         step();
         chk("R8 pulse one cycle", 32'(err_pulse), 32'd0);
      end

      // R4 backpressure
      defer_mode = 1'b0;
      m_ready = 1'b0;
      drive(32'h11111111, 4'h0, 1'b0, 1'b0, 1'b1);
      step();
      chk("R4 held beat valid", 32'(m_valid), 32'd1);
      chk("R4 s_ready low when full", 32'(s_ready), 32'd0);
      drive(32'h07030100, 4'hA, 1'b0, 1'b0, 1'b1);
      step();
      chk("R4 data held", m_data, 32'h11111111);
      m_ready = 1'b1;
      step();
      chk("R4 next beat after release", m_data, 32'h07030100);
      s_valid = 1'b0;
      step();
      chk("R4 drained", 32'(m_valid), 32'd0);

      // R6 controller write burst with a fault on beat 1
      drive(32'hFFFFFFFF, 4'h0, 1'b1, 1'b1, 1'b0);
      step();
      chk("R6 beat0 forwarded", 32'(m_valid), 32'd1);
      drive(32'hFFFFFFFF, 4'h1, 1'b1, 1'b1, 1'b0);
      step();
      chk("R5 faulty beat dropped", 32'(m_valid), 32'd0);
      chk("R8 pulse on dropped beat", 32'(err_pulse), 32'd1);
      drive(32'h07030100, 4'hA, 1'b1, 1'b1, 1'b1);
      #1;
      chk("R5 sender not stalled", 32'(s_ready), 32'd1);
      step();
      chk("R6 rest of burst dropped", 32'(m_valid), 32'd0);
      chk("R8 no pulse on clean beat", 32'(err_pulse), 32'd0);
      drive(32'h07030100, 4'hA, 1'b1, 1'b1, 1'b1);
      step();
      chk("R6 next burst forwarded", 32'(m_valid), 32'd1);
      chk("R6 next burst last tag", 32'(m_last), 32'd1);
      s_valid = 1'b0;
      step();

      // R9 consumption-side reporting
      defer_mode = 1'b1;
      use_valid = 1'b1; use_data = 32'h07030100; use_par = 4'hB;
      step();
      chk("R9 pulse on poisoned use", 32'(err_pulse), 32'd1);
      use_par = 4'hA;
      step();
      chk("R9 no pulse on clean use", 32'(err_pulse), 32'd0);

      // R10 consumption ignored in immediate mode
      defer_mode = 1'b0;
      use_par = 4'h5;
      step();
      chk("R10 use ignored", 32'(err_pulse), 32'd0);
      use_valid = 1'b0;
      step();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule